// File: doc/BRIEF.md
# Virtio PCI Configuration Register Window

This block is the register file behind the configuration window of a virtio 1.0 device's main memory BAR. A host-side register bus presents a byte offset, a read or write flag, an access size of 1, 2 or 4 bytes and write data. One cycle later the block answers with an acknowledge, read data and an error flag. The window has three parts. The common configuration registers sit at the bottom. Above them is a single interrupt status byte. Above that is a pass-through window that forwards accesses, rebased to zero, to a device-specific configuration port supplied by the device model.

The block holds the feature-word selectors, the accepted driver feature word, the device status byte and the queue selector. It also keeps a queue size and six 32-bit ring address words for each of a parameterised number of queues. The interrupt status byte collects per-bit strobes from the device and drives a level interrupt line; reading the byte clears it. A status write that sets the driver-ready bit emits a single-cycle ready pulse toward the device.

Top module: `vio_cfg_regs`

## Requirements
- R1: Offsets 0x00-0x37 decode as common registers. 0x38 is the interrupt status byte. 0x3C up to 0x3C+DEV_BYTES-1 is the device window. Every other offset, and any common offset that holds no register, answers with an error. Writes to 0x38 are errors.
- R2: Device features (0x04) reads DEV_FEAT when the device select (0x00) is 0, reads 1 when the select is 1, and reads 0 otherwise.
- R3: A driver features (0x0C) write is stored only while the driver select (0x08) is 0. A driver features read returns 0 while that select is nonzero.
- R4: Both selects, both feature words and the ring words accept only 4-byte accesses. Device status (0x14) accepts only 1-byte accesses. Queue select (0x16) and queue size (0x18) accept only 2-byte accesses. Any other size answers with an error and changes nothing.
- R5: A queue select write of a value at or above NUM_Q is an error and keeps the old select. Queue size, ring word and notify offset accesses are errors while the select is out of range.
- R6: Queue size and the ring words are stored per queue, addressed by the current select. Ring word k sits at 0x20+4k, for k from 0 to 5.
- R7: The notify offset register (0x1E) reads the current queue select.
- R8: Queue enable (0x1C), both MSI-X vector registers (0x10, 0x1A) and config generation (0x15) read 0. Writes to queue enable and to the MSI-X registers complete without error and have no effect.
- R9: Writes to num_queues (0x12, which reads NUM_Q), notify offset, config generation and device features answer with an error.
- R10: Bit i of the interrupt status byte is set by a one-cycle strobe on irq_set[i]. irq_out is high while any bit is set. A read of 0x38 returns the byte and clears it; a strobe in the same cycle as the read survives the clear.
- R11: A valid 1-byte status write with bit 2 (0x04) set gives dev_ready high for exactly the cycle in which its response is given.
- R12: Device window accesses appear on the devcfg_* port in the same cycle, with the offset less 0x3C. The port's read data and error become the response.
- R13: After reset all state is zero, irq_out and dev_ready are low, and every access gets bus_ack exactly one cycle after bus_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset in the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right aligned |
| bus_ack | output | 1 | Response valid, one cycle after request |
| bus_rdata | output | 32 | Read data, right aligned |
| bus_err | output | 1 | Access rejected |
| irq_set | input | 8 | Per-bit interrupt status set strobes |
| irq_out | output | 1 | Interrupt line |
| dev_ready | output | 1 | Driver-ready pulse |
| devcfg_valid | output | 1 | Device window access |
| devcfg_write | output | 1 | Device window write flag |
| devcfg_addr | output | AW | Offset inside the device window |
| devcfg_size | output | 3 | Device window access size |
| devcfg_wdata | output | 32 | Device window write data |
| devcfg_rdata | input | 32 | Device window read data, same cycle |
| devcfg_err | input | 1 | Device window error, same cycle |

## Verification
The embedded assertions check several properties on every cycle. The queue select never leaves its range, and an out-of-range select write leaves it unchanged. A wrongly sized status write errors and leaves the status stable. Each request is acknowledged one cycle later. dev_ready only follows a qualifying status write. An interrupt status read with no new strobe drops the interrupt line. The bench scenarios cover what depends on stored values and their order. This includes the feature-word views under each select, driver feature gating, the separation of per-queue ring storage, a set strobe that collides with a clearing read, and rebasing and error forwarding through the device window.

// File: rtl/vio_cfg_regs.sv
module vio_cfg_regs #(
  parameter int AW = 8,
  parameter int NUM_Q = 4,
  parameter int DEV_BYTES = 16,
  parameter logic [31:0] DEV_FEAT = 32'h0000_0021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [2:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ack,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic [7:0]    irq_set,
  output logic          irq_out,
  output logic          dev_ready,
  output logic          devcfg_valid,
  output logic          devcfg_write,
  output logic [AW-1:0] devcfg_addr,
  output logic [2:0]    devcfg_size,
  output logic [31:0]   devcfg_wdata,
  input  logic [31:0]   devcfg_rdata,
  input  logic          devcfg_err
);
  localparam int QIW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int CMN_END = 'h38;
  localparam int ISR_OFF = 'h38;
  localparam int DEV_BASE = 'h3C;
  localparam int DEV_END = DEV_BASE + DEV_BYTES;

  logic [31:0] dfsel, drfsel, drfeat;
  logic [7:0]  dstat, isr;
  logic [15:0] qsel;
  logic [15:0] qsize [NUM_Q];
  logic [31:0] ring  [NUM_Q][6];

  logic [31:0]    ax;
  logic [QIW-1:0] qi;
  logic           qok, sz1, sz2, sz4, wr;
  assign ax  = 32'(bus_addr);
  assign qi  = qsel[QIW-1:0];
  assign qok = 32'(qsel) < NUM_Q;
  assign sz1 = bus_size == 3'd1;
  assign sz2 = bus_size == 3'd2;
  assign sz4 = bus_size == 3'd4;
  assign wr  = bus_valid & bus_write;

  logic        err_c, in_dev, isr_rd;
  logic        we_dfs, we_drs, we_drf, we_st, we_qs, we_qz, we_rg;
  logic [31:0] rd_c;

  always_comb begin
    err_c = 1'b0; rd_c = '0; in_dev = 1'b0; isr_rd = 1'b0;
    we_dfs = 1'b0; we_drs = 1'b0; we_drf = 1'b0; we_st = 1'b0;
    we_qs = 1'b0; we_qz = 1'b0; we_rg = 1'b0;
    if (ax < CMN_END) begin
      case (ax)
        32'h00: if (!sz4) err_c = 1'b1; else begin rd_c = dfsel; we_dfs = wr; end
        32'h04: if (bus_write || !sz4) err_c = 1'b1;
                else rd_c = (dfsel == 0) ? DEV_FEAT : (dfsel == 1) ? 32'd1 : 32'd0;
        32'h08: if (!sz4) err_c = 1'b1; else begin rd_c = drfsel; we_drs = wr; end
        32'h0C: if (!sz4) err_c = 1'b1;
                else begin rd_c = (drfsel != 0) ? 32'd0 : drfeat; we_drf = wr; end
        32'h10, 32'h1A, 32'h1C: rd_c = '0;
        32'h12: if (bus_write) err_c = 1'b1; else rd_c = 32'(NUM_Q);
        32'h14: if (!sz1) err_c = 1'b1; else begin rd_c = {24'b0, dstat}; we_st = wr; end
        32'h15: if (bus_write) err_c = 1'b1;
        32'h16: if (!sz2) err_c = 1'b1;
                else if (bus_write && 32'(bus_wdata[15:0]) >= NUM_Q) err_c = 1'b1;
                else begin rd_c = {16'b0, qsel}; we_qs = wr; end
        32'h18: if (!sz2 || !qok) err_c = 1'b1;
                else begin rd_c = {16'b0, qsize[qi]}; we_qz = wr; end
        32'h1E: if (bus_write || !qok) err_c = 1'b1; else rd_c = {16'b0, qsel};
        default:
          if (ax >= 32'h20 && ax[1:0] == 2'b00) begin
            if (!sz4 || !qok) err_c = 1'b1;
            else begin rd_c = ring[qi][ax[4:2]]; we_rg = wr; end
          end else err_c = 1'b1;
      endcase
    end else if (ax == ISR_OFF) begin
      if (bus_write) err_c = 1'b1;
      else begin rd_c = {24'b0, isr}; isr_rd = bus_valid; end
    end else if (ax >= DEV_BASE && ax < DEV_END) begin
      in_dev = 1'b1; rd_c = devcfg_rdata; err_c = devcfg_err;
    end else err_c = 1'b1;
  end

  assign devcfg_valid = bus_valid & in_dev;
  assign devcfg_write = bus_write;
  assign devcfg_addr  = AW'(ax - DEV_BASE);
  assign devcfg_size  = bus_size;
  assign devcfg_wdata = bus_wdata;
  assign irq_out      = |isr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dfsel <= '0; drfsel <= '0; drfeat <= '0; dstat <= '0; qsel <= '0; isr <= '0;
      bus_ack <= 1'b0; bus_rdata <= '0; bus_err <= 1'b0; dev_ready <= 1'b0;
      for (int q = 0; q < NUM_Q; q++) begin
        qsize[q] <= '0;
        for (int k = 0; k < 6; k++) ring[q][k] <= '0;
      end
    end else begin
      bus_ack   <= bus_valid;
      bus_err   <= bus_valid & err_c;
      bus_rdata <= (bus_valid && !bus_write && !err_c) ? rd_c : 32'd0;
      dev_ready <= we_st & bus_wdata[2];
      isr       <= (isr_rd ? 8'd0 : isr) | irq_set;
      if (we_dfs) dfsel <= bus_wdata;
      if (we_drs) drfsel <= bus_wdata;
      if (we_drf && drfsel == 0) drfeat <= bus_wdata;
      if (we_st) dstat <= bus_wdata[7:0];
      if (we_qs) qsel <= bus_wdata[15:0];
      for (int q = 0; q < NUM_Q; q++) begin
        if (we_qz && qi == QIW'(q)) qsize[q] <= bus_wdata[15:0];
        if (we_rg && qi == QIW'(q)) ring[q][ax[4:2]] <= bus_wdata;
      end
    end
  end

  assert_qsel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(qsel) < NUM_Q);

  assert_qsel_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ax == 32'h16 && sz2 && 32'(bus_wdata[15:0]) >= NUM_Q) |=> (bus_err && $stable(qsel)));

  assert_status_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ax == 32'h14 && !sz1) |=> (bus_err && $stable(dstat)));

  assert_ack_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_ack);

  assert_ready_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> $past(wr && ax == 32'h14 && sz1 && bus_wdata[2]));

  assert_isr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && ax == 32'h38 && irq_set == 8'd0) |=> !irq_out);
endmodule

// File: tb/sim_vio_cfg_regs.sv
`timescale 1ns/1ps
module sim_vio_cfg_regs;
  localparam int AW = 8;
  localparam int NQ = 4;
  localparam int DB = 16;
  localparam logic [31:0] FEAT = 32'h0000_0021;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0] bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err, irq_out, dev_ready;
  logic [31:0] bus_rdata;
  logic [7:0] irq_set = '0;
  logic devcfg_valid, devcfg_write;
  logic [AW-1:0] devcfg_addr;
  logic [2:0] devcfg_size;
  logic [31:0] devcfg_wdata, devcfg_rdata;
  logic devcfg_err;

  always #4 clk = ~clk;

  vio_cfg_regs #(.AW(AW), .NUM_Q(NQ), .DEV_BYTES(DB), .DEV_FEAT(FEAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_set(irq_set), .irq_out(irq_out), .dev_ready(dev_ready),
    .devcfg_valid(devcfg_valid), .devcfg_write(devcfg_write),
    .devcfg_addr(devcfg_addr), .devcfg_size(devcfg_size),
    .devcfg_wdata(devcfg_wdata), .devcfg_rdata(devcfg_rdata),
    .devcfg_err(devcfg_err));

  // device window model: data tags the offset, last byte errors
  assign devcfg_rdata = 32'hA500_0000 | 32'(devcfg_addr);
  assign devcfg_err   = devcfg_valid && (32'(devcfg_addr) == DB - 1);
  logic [AW-1:0] seen_a = '0;
  logic [31:0]   seen_d = '0;
  always @(posedge clk)
    if (devcfg_valid && devcfg_write) begin seen_a <= devcfg_addr; seen_d <= devcfg_wdata; end

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_d[$];
  bit exp_e[$], exp_c[$];
  string exp_t[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (exp_d.size() == 0) chk(0, "R13 unexpected ack", 32'd1, 32'd0);
      else begin
        logic [31:0] d; bit e, c; string t;
        d = exp_d.pop_front(); e = exp_e.pop_front();
        c = exp_c.pop_front(); t = exp_t.pop_front();
        chk(bus_err == e, {t, " err"}, 32'(bus_err), 32'(e));
        if (c && !e) chk(bus_rdata == d, {t, " data"}, bus_rdata, d);
      end
    end
  end

  task automatic acc(input bit w, input logic [7:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input logic [7:0] irq,
                     input bit c, input logic [31:0] ed, input bit ee, input string tag);
    exp_d.push_back(ed); exp_e.push_back(ee); exp_c.push_back(c); exp_t.push_back(tag);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = wd; irq_set = irq;
    @(negedge clk);
    bus_valid = 1'b0; irq_set = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] ed, input string tag);
    acc(0, a, sz, 0, 0, 1, ed, 0, tag);
  endtask
  task automatic rde(input logic [7:0] a, input logic [2:0] sz, input string tag);
    acc(0, a, sz, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd, input string tag);
    acc(1, a, sz, wd, 0, 0, 0, 0, tag);
  endtask
  task automatic wre(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd, input string tag);
    acc(1, a, sz, wd, 0, 0, 0, 1, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog R13 act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_ack == 0 && irq_out == 0 && dev_ready == 0, "R13 reset outputs",
        {29'b0, bus_ack, irq_out, dev_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h12, 2, NQ, "R9 num_queues");
    rd(8'h14, 1, 0, "R13 status reset");
    rd(8'h20, 4, 0, "R13 ring reset");
    // R2 feature word views
    wr(8'h00, 4, 0, "R2 sel0");
    rd(8'h04, 4, FEAT, "R2 word0");
    wr(8'h00, 4, 1, "R2 sel1");
    rd(8'h04, 4, 1, "R2 word1");
    wr(8'h00, 4, 2, "R2 sel2");
    rd(8'h04, 4, 0, "R2 word2");
    wre(8'h04, 4, 5, "R9 devfeat write");
    // R3 driver features gating
    wr(8'h0C, 4, 32'hDEADBEEF, "R3 store");
    rd(8'h0C, 4, 32'hDEADBEEF, "R3 readback");
    wr(8'h08, 4, 1, "R3 sel1");
    rd(8'h0C, 4, 0, "R3 masked");
    wr(8'h0C, 4, 32'h1234, "R3 ignored write");
    wr(8'h08, 4, 0, "R3 sel0");
    rd(8'h0C, 4, 32'hDEADBEEF, "R3 kept");
    // R4 size checks
    wre(8'h00, 2, 7, "R4 sel size");
    rd(8'h00, 4, 2, "R4 sel unchanged");
    wre(8'h14, 4, 8'h55, "R4 status size");
    rd(8'h14, 1, 0, "R4 status unchanged");
    rde(8'h16, 4, "R4 qsel size");
    // R5 queue select range
    wr(8'h16, 2, 2, "R5 qsel 2");
    rd(8'h16, 2, 2, "R5 qsel read");
    wre(8'h16, 2, NQ, "R5 qsel too big");
    rd(8'h16, 2, 2, "R5 qsel kept");
    // R6 per-queue storage
    wr(8'h18, 2, 16'h0100, "R6 qsize");
    wre(8'h18, 4, 16'h0200, "R4 qsize size");
    for (int k = 0; k < 6; k++) wr(8'(8'h20 + 4 * k), 4, 32'h1000 + 32'(k) * 32'h11, "R6 ring wr");
    wr(8'h16, 2, 1, "R6 sel q1");
    rd(8'h18, 2, 0, "R6 q1 size");
    rd(8'h2C, 4, 0, "R6 q1 ring");
    wr(8'h16, 2, 2, "R6 sel q2");
    rd(8'h18, 2, 16'h0100, "R6 q2 size");
    for (int k = 0; k < 6; k++) rd(8'(8'h20 + 4 * k), 4, 32'h1000 + 32'(k) * 32'h11, "R6 ring rd");
    rde(8'h22, 4, "R1 unaligned ring");
    // R7 notify offset
    wr(8'h16, 2, 3, "R7 sel q3");
    rd(8'h1E, 2, 3, "R7 notify off");
    wre(8'h1E, 2, 0, "R9 notify write");
    // R8 always-zero registers
    wr(8'h1C, 2, 1, "R8 qenable write");
    rd(8'h1C, 2, 0, "R8 qenable read");
    wr(8'h10, 2, 5, "R8 msix write");
    rd(8'h10, 2, 0, "R8 msix read");
    wr(8'h1A, 2, 6, "R8 qmsix write");
    rd(8'h1A, 2, 0, "R8 qmsix read");
    rd(8'h15, 1, 0, "R8 cfggen read");
    wre(8'h15, 1, 1, "R9 cfggen write");
    wre(8'h12, 2, 9, "R9 numq write");
    // R1 decode holes
    rde(8'h02, 4, "R1 hole 02");
    rde(8'h39, 1, "R1 hole 39");
    rde(8'h4C, 4, "R1 past window");
    rde(8'h60, 4, "R1 far");
    wre(8'h38, 1, 0, "R1 isr write");
    // R10 interrupt status
    irq_set = 8'h01; @(negedge clk); irq_set = 8'h00;
    chk(irq_out == 1, "R10 irq set", 32'(irq_out), 32'd1);
    acc(0, 8'h38, 1, 0, 8'h02, 1, 32'h01, 0, "R10 read with strobe");
    chk(irq_out == 1, "R10 strobe survives", 32'(irq_out), 32'd1);
    rd(8'h38, 1, 32'h02, "R10 second read");
    chk(irq_out == 0, "R10 cleared", 32'(irq_out), 32'd0);
    rd(8'h38, 1, 0, "R10 empty");
    // R11 ready pulse
    wr(8'h14, 1, 8'h03, "R11 no ready");
    chk(dev_ready == 0, "R11 no pulse", 32'(dev_ready), 32'd0);
    wr(8'h14, 1, 8'h07, "R11 ready write");
    chk(dev_ready == 1, "R11 pulse", 32'(dev_ready), 32'd1);
    @(negedge clk);
    chk(dev_ready == 0, "R11 one cycle", 32'(dev_ready), 32'd0);
    rd(8'h14, 1, 8'h07, "R11 status read");
    // R12 device window
    rd(8'h41, 4, 32'hA500_0005, "R12 dev read");
    rde(8'h4B, 4, "R12 dev err");
    wr(8'h3E, 1, 32'h55, "R12 dev write");
    chk(seen_a == 8'd2 && seen_d == 32'h55, "R12 dev write seen", {seen_a, seen_d[23:0]}, {8'd2, 24'h55});
    repeat (3) @(negedge clk);
    chk(exp_d.size() == 0, "R13 all responses", 32'(exp_d.size()), 32'd0);
    finish_run();
  end
endmodule